// File: doc/BRIEF.md
# Burst-Limited DMA Request Generator

This block drives the DMA request line of a parallel-port data FIFO. It raises the request when software has enabled DMA and no service condition is pending, and when the FIFO can take part in a transfer in the selected direction. In the outbound direction DMA fills the FIFO, so a free word slot is needed. In the inbound direction DMA drains the FIFO, so a valid word is needed. Every DMA access targets the single FIFO data address, so the block only decides *when* to request and never *where*.

A DMA cycle is a clock in which the request and the acknowledge are both high. The block counts these cycles during each unbroken stretch of request. If a stretch grows too long, it cuts the request, keeps it low for a short gap, and then starts a fresh count. This keeps memory refresh from being starved.

When an acknowledged cycle arrives with the terminal-count input high, the block drops the request. It also emits a one-cycle pulse that tells the control register to set its service bit, which raises the interrupt. Until that service bit is seen, the block keeps the request low.

Top module: `dma_req_gen`

## Requirements
- R1: After reset, `dma_req` and `svc_set` are both 0.
- R2: `dma_req` can be 1 only if, in the previous cycle, `dma_en` was 1 and `svc_pend` was 0. Setting `dma_en` to 0 drops the request at the next clock edge.
- R3: If `dir_rev` is 0 (outbound), the request needs `fifo_free` = 1 and ignores `fifo_valid`. If `dir_rev` is 1 (inbound), it needs `fifo_valid` = 1 and ignores `fifo_free`.
- R4: The request rises at the clock edge after all its conditions are true. It falls at the edge after any condition becomes false.
- R5: A DMA cycle is a cycle with both `dma_req` and `dma_ack` high. After BURST_MAX (default 32) DMA cycles within one unbroken assertion, `dma_req` is 0 at the next edge. The request is therefore never high for more than BURST_MAX DMA cycles in a row.
- R6: After a burst is cut, `dma_req` stays 0 for IDLE_MIN cycles (default 1). It then returns if the conditions still hold, and a full new burst of BURST_MAX DMA cycles is allowed.
- R7: The burst count clears whenever the request deasserts, whatever the cause. After a partial burst and a drop, a full BURST_MAX DMA cycles are allowed again.
- R8: A DMA cycle with `term_cnt` high makes `dma_req` 0 at the next edge. In that same cycle, `svc_set` is 1, and only for that one cycle.
- R9: After a terminal count, `dma_req` stays 0, even while `svc_pend` is still 0, until `svc_pend` = 1 or `dma_en` = 0 has been seen. After that, it resumes once `dma_en` = 1 and `svc_pend` = 0.
- R10: Raising `svc_pend` in the middle of a transfer drops the request at the next edge. Clearing it resumes the request at the following edge.
- R11: A `dma_ack` that arrives while `dma_req` is 0 is not counted toward the burst limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | DMA enable from the control register |
| svc_pend | input | 1 | Service bit; 1 blocks requests |
| dir_rev | input | 1 | 0 = outbound (fill FIFO), 1 = inbound (drain FIFO) |
| fifo_free | input | 1 | FIFO has at least one free word slot |
| fifo_valid | input | 1 | FIFO holds at least one valid word |
| dma_ack | input | 1 | DMA acknowledge from the bus controller |
| term_cnt | input | 1 | Terminal count reached on this cycle |
| dma_req | output | 1 | DMA request |
| svc_set | output | 1 | One-cycle pulse to set the service bit |

## Verification
Several rules are checked by assertions on every cycle:
- a raised request always follows a cycle with DMA enabled, no service pending and a ready FIFO;
- the burst count never reaches the limit;
- the request is low whenever the gap timer or the terminal-count hold is active;
- a terminal count is followed by a single `svc_set` pulse and a dropped request.

Other behaviour needs the directed scenarios:
- the exact length of a burst, including after a partial burst or after acknowledges given while idle;
- the length of the gap;
- resumption after the service bit is set and cleared;
- the fact that the unused FIFO indication is ignored.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
  parameter int BURST_MAX = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_q,
  input  logic ack,
  input  logic req_nxt,
  output logic last_beat
);
  localparam int CW = $clog2(BURST_MAX + 1);
  localparam logic [CW-1:0] LAST = CW'(BURST_MAX - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          beat;

  assign beat      = req_q & ack;
  assign last_beat = beat && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!req_nxt)  cnt_d = '0;
    else if (beat) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the count of DMA cycles stays below the limit
  a_r5_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R7: an idle request always leaves the count cleared
  a_r7_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> cnt_q == '0);
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int IDLE_MIN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int GW = $clog2(IDLE_MIN + 1);
  localparam logic [GW-1:0] LOADV = GW'(IDLE_MIN - 1);

  logic [GW-1:0] gap_q, gap_d;

  assign busy = (gap_q != '0);

  always_comb begin
    gap_d = gap_q;
    if (load)      gap_d = LOADV;
    else if (busy) gap_d = gap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_d;
  end

  // R6: the gap never exceeds its configured length
  a_r6_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= LOADV);
endmodule

// File: rtl/dma_tc_guard.sv
module dma_tc_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_hit,
  input  logic svc_pend,
  input  logic dma_en,
  output logic svc_set,
  output logic hold
);
  logic set_q, hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (tc_hit)                   hold_d = 1'b1;
    else if (svc_pend || !dma_en) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      set_q  <= tc_hit;
      hold_q <= hold_d;
    end
  end

  assign svc_set = set_q;
  assign hold    = hold_q;

  // R8: the service pulse lasts exactly one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    svc_set |=> !svc_set);
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int BURST_MAX = 32,
  parameter int IDLE_MIN  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic svc_pend,
  input  logic dir_rev,
  input  logic fifo_free,
  input  logic fifo_valid,
  input  logic dma_ack,
  input  logic term_cnt,
  output logic dma_req,
  output logic svc_set
);
  import dma_req_pkg::*;

  xfer_dir_e dir;
  logic      req_q, req_d;
  logic      fifo_ok, tc_hit, last_beat, gap_busy, tc_hold;

  assign dir     = xfer_dir_e'(dir_rev);
  assign fifo_ok = (dir == DIR_REV) ? fifo_valid : fifo_free;
  assign tc_hit  = req_q & dma_ack & term_cnt;

  always_comb begin
    req_d = dma_en & ~svc_pend & fifo_ok;
    if (gap_busy || tc_hold || last_beat || tc_hit) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  dma_burst_ctr #(.BURST_MAX(BURST_MAX)) u_burst (
    .clk(clk), .rst_n(rst_n), .req_q(req_q), .ack(dma_ack),
    .req_nxt(req_d), .last_beat(last_beat));

  dma_gap_timer #(.IDLE_MIN(IDLE_MIN)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(last_beat), .busy(gap_busy));

  dma_tc_guard u_tc (
    .clk(clk), .rst_n(rst_n), .tc_hit(tc_hit), .svc_pend(svc_pend),
    .dma_en(dma_en), .svc_set(svc_set), .hold(tc_hold));

  assign dma_req = req_q;

  // R2: a request follows an enabled, non-pending cycle
  a_r2_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(dma_en && !svc_pend));
  // R3: a request follows a cycle where the FIFO could serve the direction
  a_r3_req_needs_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(dir_rev ? fifo_valid : fifo_free));
  // R5: the final DMA cycle of a burst drops the request
  a_r5_burst_cut: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !dma_req);
  // R6: no request while the idle gap runs
  a_r6_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |=> !dma_req);
  // R8: terminal count drops the request and pulses the service output
  a_r8_tc_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && term_cnt) |=> (svc_set && !dma_req));
  // R9: no request while the terminal-count hold is active
  a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hold |=> !dma_req);
endmodule

// File: tb/test_dma_req_gen.sv
module test_dma_req_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic dma_en, svc_pend, dir_rev, fifo_free, fifo_valid, dma_ack, term_cnt;
  logic dma_req, svc_set;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_gen i_dma_req_gen (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .svc_pend(svc_pend),
    .dir_rev(dir_rev), .fifo_free(fifo_free), .fifo_valid(fifo_valid),
    .dma_ack(dma_ack), .term_cnt(term_cnt), .dma_req(dma_req), .svc_set(svc_set));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string rq, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FIFO-REQ FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  task automatic idle();
    dma_en = 0; svc_pend = 0; dir_rev = 0; fifo_free = 0; fifo_valid = 0;
    dma_ack = 0; term_cnt = 0;
    step(); step();
  endtask

  // counts consecutive cycles with dma_req high (dma_ack assumed high)
  task automatic run_len(output int n);
    n = 0;
    while (dma_req && n < 100) begin n++; step(); end
  endtask

  task automatic t_reset();
    rst_n = 0; dma_en = 0; svc_pend = 0; dir_rev = 0; fifo_free = 0;
    fifo_valid = 0; dma_ack = 0; term_cnt = 0;
    step(); step();
    check(dma_req == 0, "R1 req", dma_req, 0);
    check(svc_set == 0, "R1 svc_set", svc_set, 0);
    rst_n = 1; step();
  endtask

  task automatic t_enable();
    idle();
    fifo_free = 1; svc_pend = 1; dma_en = 1; step();
    check(dma_req == 0, "R2 blocked by svc_pend", dma_req, 0);
    svc_pend = 0; dma_en = 0; step();
    check(dma_req == 0, "R2 blocked by dma_en", dma_req, 0);
    dma_en = 1; step();
    check(dma_req == 1, "R4 rises next edge", dma_req, 1);
    dma_en = 0; step();
    check(dma_req == 0, "R2 enable drop", dma_req, 0);
  endtask

  task automatic t_direction();
    idle();
    dma_en = 1; dir_rev = 0; fifo_free = 0; fifo_valid = 1; step();
    check(dma_req == 0, "R3 fwd ignores valid", dma_req, 0);
    fifo_free = 1; fifo_valid = 0; step();
    check(dma_req == 1, "R3 fwd free", dma_req, 1);
    dir_rev = 1; step();
    check(dma_req == 0, "R3 rev ignores free", dma_req, 0);
    fifo_valid = 1; fifo_free = 0; step();
    check(dma_req == 1, "R3 rev valid", dma_req, 1);
    fifo_valid = 0; step();
    check(dma_req == 0, "R4 falls next edge", dma_req, 0);
  endtask

  task automatic t_burst();
    int n;
    idle();
    dma_ack = 1; step(); step();            // R11: acks while idle
    dma_en = 1; fifo_free = 1; step();
    run_len(n);
    check(n == 32, "R11/R5 burst length", n, 32);
    check(dma_req == 0, "R6 gap low", dma_req, 0);
    step();
    check(dma_req == 1, "R6 resumes after one idle", dma_req, 1);
    run_len(n);
    check(n == 32, "R6 second full burst", n, 32);
  endtask

  task automatic t_partial();
    int n;
    idle();
    dma_en = 1; fifo_free = 1; dma_ack = 1; step();
    for (int i = 0; i < 20; i++) step();
    fifo_free = 0; step();
    check(dma_req == 0, "R7 drop on full FIFO", dma_req, 0);
    fifo_free = 1; step();
    check(dma_req == 1, "R7 rise again", dma_req, 1);
    run_len(n);
    check(n == 32, "R7 count restarted", n, 32);
  endtask

  task automatic t_tc();
    idle();
    dma_en = 1; fifo_free = 1; dma_ack = 1; step(); step();
    term_cnt = 1; step(); term_cnt = 0;
    check(dma_req == 0, "R8 req dropped", dma_req, 0);
    check(svc_set == 1, "R8 pulse", svc_set, 1);
    step();
    check(svc_set == 0, "R8 pulse single", svc_set, 0);
    step(); step();
    check(dma_req == 0, "R9 held off", dma_req, 0);
    svc_pend = 1; step();
    check(dma_req == 0, "R9 svc seen", dma_req, 0);
    svc_pend = 0; step();
    check(dma_req == 1, "R9 resumes", dma_req, 1);
  endtask

  task automatic t_service();
    idle();
    dma_en = 1; fifo_valid = 1; dir_rev = 1; dma_ack = 1; step(); step();
    svc_pend = 1; step();
    check(dma_req == 0, "R10 mid-transfer drop", dma_req, 0);
    check(svc_set == 0, "R10 no pulse", svc_set, 0);
    svc_pend = 0; step();
    check(dma_req == 1, "R10 resume", dma_req, 1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_direction();
    t_burst();
    t_partial();
    t_tc();
    t_service();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FIFO-REQ FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule